// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block watches the sampled level of a LIN bus while the transceiver sits in one of its low-power modes (silent or sleep). It decides when a remote node has asked this node to wake up. A valid request has three parts, in this order: a recessive-to-dominant edge, a dominant level that lasts at least a programmable filter time, and then the dominant-to-recessive edge that ends it. When all three are seen, the block raises a one-cycle wake request. That request is meant for the mode controller, which then moves the node back to its fail-safe state.

The analog front end is outside this block. It supplies a bus level that is already synchronised to the block clock (1 = recessive, 0 = dominant). It also supplies a pre-wake indication, high when the bus voltage has dropped below the pre-wake threshold. The filter time is counted in ticks of an external 1 µs strobe. A bus that stays shorted to ground never produces a request while the short lasts. When the short clears, the release edge is taken as a valid wake-up. Dropping the low-power flag clears the detector at once.

Top module: `lin_wake_filter`

## Requirements
- R1: After reset, `wake_req` is 0 and the detector is idle. The last bus level held in the detector is taken as recessive.
- R2: A wake sequence starts only on a 1-to-0 change of `bus_lvl` seen while `lowpwr` is 1. A bus that is already dominant when low-power mode begins gives no request when it is released.
- R3: The detector is armed only once `prewake_low` has been 1, in the same cycle as the falling edge or in any earlier cycle of the current low-power stay. A falling edge seen while the detector is not armed is ignored.
- R4: A dominant period is released before `FILTER_TICKS` ticks have been counted (for example, `FILTER_TICKS`-1). It ends with no request, and the detector returns to idle.
- R5: A dominant period is released after at least `FILTER_TICKS` ticks. The request is then 1 in the clock cycle that follows the cycle in which `bus_lvl` is first sampled as 1. Ticks are counted on cycles after the entry cycle, while the bus is still dominant.
- R6: While the bus stays dominant, no request is issued, however long the level lasts. The release that ends such a period issues the request.
- R7: `wake_req` is never high for two cycles in a row.
- R8: While `lowpwr` is 0, the detector is cleared to idle in the next cycle and the arming is dropped. A release after `lowpwr` has fallen issues no request.
- R9: The dwell counter saturates at `FILTER_TICKS` and never wraps, so an arbitrarily long dominant level still qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_lvl | input | 1 | Synchronised bus level, 1 = recessive, 0 = dominant |
| prewake_low | input | 1 | Bus voltage below the pre-wake threshold |
| lowpwr | input | 1 | Interface is in silent or sleep mode |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| wake_req | output | 1 | One-cycle remote wake-up request |

## Verification
A fault in the dwell counter or in the sequencer shows up at `wake_req` in the cycle after a release edge. The request is either missing where it was due or present where it was not. So a single dominant pulse of exactly `FILTER_TICKS` or `FILTER_TICKS`-1 ticks exposes a counter that is off by one. A lost arming flag or a stale state after the low-power flag drops shows up only at the next release, so each scenario ends with a release edge. The bench compares the request against a behavioural model on every cycle.

// File: rtl/lwf_pkg.sv
`timescale 1ns/1ps
package lwf_pkg;

  typedef enum logic [1:0] {
    LWF_IDLE = 2'd0,
    LWF_DOM  = 2'd1,
    LWF_QUAL = 2'd2
  } lwf_state_e;

  // one saturating step of the dwell count
  function automatic int unsigned lwf_sat_step(int unsigned cur, int unsigned lim);
    return (cur < lim) ? cur + 1 : lim;
  endfunction

  // has the dominant period lasted long enough
  function automatic logic lwf_dwell_met(int unsigned cur, int unsigned lim);
    return cur >= lim;
  endfunction

endpackage

// File: rtl/lwf_edge.sv
`timescale 1ns/1ps
module lwf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_lvl,
  output logic bus_prev,
  output logic fell,
  output logic rose
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_prev <= 1'b1;
    else        bus_prev <= bus_lvl;
  end

  assign fell = bus_prev & ~bus_lvl;
  assign rose = ~bus_prev & bus_lvl;

  // R2: a detected fall leaves the held level dominant
  a_r2_fall_holds_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !bus_prev);

  a_r2_rise_holds_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    rose |=> bus_prev);

endmodule

// File: rtl/lwf_arm.sv
`timescale 1ns/1ps
module lwf_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic lowpwr,
  input  logic prewake_low,
  output logic arm_ok
);

  logic arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           arm_q <= 1'b0;
    else if (!lowpwr)     arm_q <= 1'b0;
    else if (prewake_low) arm_q <= 1'b1;
  end

  assign arm_ok = lowpwr & (arm_q | prewake_low);

  // R3: arming, once gained in a low-power stay, is kept for that stay
  a_r3_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_ok && lowpwr) |=> (lowpwr -> arm_ok));

  // R8: arming never survives a cycle out of low-power mode
  a_r8_arm_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !lowpwr |=> (arm_ok -> prewake_low));

endmodule

// File: rtl/lwf_dwell.sv
`timescale 1ns/1ps
module lwf_dwell #(
  parameter int unsigned FILTER_TICKS = 90,
  localparam int unsigned CNT_W = $clog2(FILTER_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             met
);
  import lwf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= CNT_W'(lwf_sat_step(int'(cnt), FILTER_TICKS));
  end

  assign met = lwf_dwell_met(int'(cnt), FILTER_TICKS);

  // R9: counting past the limit never wraps back below it
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (met && inc && !clr) |=> met);

  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= FILTER_TICKS);

endmodule

// File: rtl/lwf_seq.sv
`timescale 1ns/1ps
module lwf_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lowpwr,
  input  logic              arm_ok,
  input  logic              fell,
  input  logic              rose,
  input  logic              met,
  input  logic              tick_us,
  output lwf_pkg::lwf_state_e st,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              wake_req
);
  import lwf_pkg::*;

  lwf_state_e st_nx;
  logic       fire;
  logic       start;

  assign start = arm_ok & fell;
  assign fire  = lowpwr & rose & (st == LWF_QUAL || (st == LWF_DOM && met));

  always_comb begin
    st_nx   = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!lowpwr) begin
      st_nx   = LWF_IDLE;
      cnt_clr = 1'b1;
    end else begin
      unique case (st)
        LWF_IDLE: begin
          cnt_clr = 1'b1;
          if (start) st_nx = LWF_DOM;
        end
        LWF_DOM: begin
          if (rose)      st_nx = LWF_IDLE;
          else if (met)  st_nx = LWF_QUAL;
          else           cnt_inc = tick_us;
        end
        LWF_QUAL: begin
          if (rose) st_nx = LWF_IDLE;
        end
        default: st_nx = LWF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LWF_IDLE;
      wake_req <= 1'b0;
    end else begin
      st       <= st_nx;
      wake_req <= fire;
    end
  end

  // R2: idle is left only through an armed falling edge
  a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LWF_IDLE && !fell) |=> st == LWF_IDLE);

  // R3: without arming the detector stays idle
  a_r3_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LWF_IDLE && !arm_ok) |=> st == LWF_IDLE);

  // R4: a short dominant pulse returns to idle with no request
  a_r4_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LWF_DOM && rose && !met) |=> (st == LWF_IDLE && !wake_req));

  // R6: no request while the bus stays dominant
  a_r6_no_wake_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LWF_QUAL && !rose) |=> !wake_req);

  // R8: out of low-power mode the detector is idle next cycle
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !lowpwr |=> (st == LWF_IDLE && !wake_req));

endmodule

// File: rtl/lin_wake_filter.sv
`timescale 1ns/1ps
module lin_wake_filter #(
  parameter int unsigned FILTER_TICKS = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_lvl,
  input  logic prewake_low,
  input  logic lowpwr,
  input  logic tick_us,
  output logic wake_req
);
  import lwf_pkg::*;

  localparam int unsigned CNT_W = $clog2(FILTER_TICKS + 1);

  logic             bus_prev;
  logic             fell;
  logic             rose;
  logic             arm_ok;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             met;
  logic [CNT_W-1:0] dwell_cnt;
  lwf_state_e       st;

  lwf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl),
    .bus_prev(bus_prev), .fell(fell), .rose(rose)
  );

  lwf_arm u_arm (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr),
    .prewake_low(prewake_low), .arm_ok(arm_ok)
  );

  lwf_dwell #(.FILTER_TICKS(FILTER_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(dwell_cnt), .met(met)
  );

  lwf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .arm_ok(arm_ok),
    .fell(fell), .rose(rose), .met(met), .tick_us(tick_us),
    .st(st), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .wake_req(wake_req)
  );

  // R7: the request lasts exactly one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  // R5: a request follows a release edge seen in low-power mode
  a_r5_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(rose) && $past(lowpwr) && bus_prev));

  // R1: the dwell count is zero whenever the detector is idle after a cycle
  a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LWF_IDLE && $past(st) == LWF_IDLE) |-> dwell_cnt == '0);

endmodule

// File: tb/test_lin_wake_filter.sv
`timescale 1ns/1ps
module test_lin_wake_filter;

  localparam int F = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_lvl = 1'b1;
  logic prewake_low = 1'b0;
  logic lowpwr = 1'b0;
  logic tick_us = 1'b0;
  logic wake_req;

  int vectors = 0;
  int fails = 0;
  int wake_cnt = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  lin_wake_filter #(.FILTER_TICKS(F)) i_lin_wake_filter (
    .clk(clk), .rst_n(rst_n), .bus_lvl(bus_lvl), .prewake_low(prewake_low),
    .lowpwr(lowpwr), .tick_us(tick_us), .wake_req(wake_req)
  );

  // behavioural reference model
  bit m_prev = 1'b1;
  bit m_armed = 1'b0;
  bit m_busy = 1'b0;
  int m_ticks = 0;
  bit m_wake = 1'b0;

  always @(posedge clk) begin
    bit nw;
    nw = 1'b0;
    if (!rst_n) begin
      m_prev = 1'b1; m_armed = 1'b0; m_busy = 1'b0; m_ticks = 0;
    end else begin
      if (!lowpwr) begin
        m_busy = 1'b0; m_armed = 1'b0; m_ticks = 0;
      end else begin
        if (!m_busy) begin
          if (m_prev && !bus_lvl && (m_armed || prewake_low)) begin
            m_busy = 1'b1; m_ticks = 0;
          end
        end else if (bus_lvl) begin
          nw = (m_ticks >= F);
          m_busy = 1'b0;
        end else if (tick_us) begin
          m_ticks = m_ticks + 1;
        end
        if (prewake_low) m_armed = 1'b1;
      end
      m_prev = bus_lvl;
    end
    m_wake = nw;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (wake_req) wake_cnt++;
      if (wake_req !== m_wake) begin
        fails++;
        $display("FAIL %s model compare: wake_req=%0b expected=%0b at %0t",
                 phase, wake_req, m_wake, $time);
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_now();
    prewake_low = 1'b1; cyc(1); prewake_low = 1'b0; cyc(1);
  endtask

  // dominant pulse with k counted ticks, then release and check the request
  task automatic dom_pulse(string tag, int k, bit exp);
    int base;
    base = wake_cnt;
    bus_lvl = 1'b0; tick_us = 1'b0; cyc(1);
    for (int i = 0; i < k; i++) begin
      tick_us = 1'b1; cyc(1); tick_us = 1'b0; cyc(1);
    end
    check({tag, " none while dominant"}, wake_cnt - base, 0);
    bus_lvl = 1'b1; cyc(1);
    check({tag, " request cycle after release"}, int'(wake_req), int'(exp));
    cyc(1);
    check({"R7 one-cycle after ", tag}, int'(wake_req), 0);
    cyc(2);
    check({tag, " total requests"}, wake_cnt - base, int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    check("R1 request low in reset", int'(wake_req), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 request low after reset", int'(wake_req), 0);

    // R3: not armed, long dominant pulse ignored
    phase = "R3"; lowpwr = 1'b1; cyc(2);
    dom_pulse("R3", F + 10, 1'b0);

    // R5: armed, qualifying pulse
    phase = "R5"; arm_now();
    dom_pulse("R5", F + 5, 1'b1);

    // R4: short pulses, including one tick below the limit
    phase = "R4";
    dom_pulse("R4", 40, 1'b0);
    dom_pulse("R4", F - 1, 1'b0);
    phase = "R5";
    dom_pulse("R5", F, 1'b1);

    // R3: prewake in the same cycle as the falling edge arms it
    phase = "R3"; lowpwr = 1'b0; cyc(2); lowpwr = 1'b1; cyc(2);
    prewake_low = 1'b1; bus_lvl = 1'b0; cyc(1); prewake_low = 1'b0;
    bus_lvl = 1'b1; cyc(1);
    dom_pulse("R3", F + 2, 1'b1);

    // R6 / R9: stuck dominant far past the limit
    phase = "R6";
    dom_pulse("R6", 3000, 1'b1);
    phase = "R9";
    dom_pulse("R9", 2 * F + 7, 1'b1);

    // R2: bus already dominant when low-power mode begins
    phase = "R2"; lowpwr = 1'b0; bus_lvl = 1'b0; cyc(3);
    lowpwr = 1'b1; prewake_low = 1'b1; cyc(2); prewake_low = 1'b0;
    base = wake_cnt;
    for (int i = 0; i < F + 10; i++) begin
      tick_us = 1'b1; cyc(1); tick_us = 1'b0; cyc(1);
    end
    bus_lvl = 1'b1; cyc(3);
    check("R2 no request without a falling edge", wake_cnt - base, 0);

    // R8: leaving low-power mode during a qualified period
    phase = "R8"; arm_now();
    base = wake_cnt;
    bus_lvl = 1'b0; cyc(1);
    for (int i = 0; i < F + 5; i++) begin
      tick_us = 1'b1; cyc(1); tick_us = 1'b0; cyc(1);
    end
    lowpwr = 1'b0; cyc(2);
    bus_lvl = 1'b1; cyc(3);
    check("R8 no request after leaving low power", wake_cnt - base, 0);
    // re-entering low power drops old arming
    lowpwr = 1'b1; cyc(2);
    dom_pulse("R8", F + 3, 1'b0);

    // R8: dropping the mode in mid pulse and returning keeps it idle
    arm_now();
    base = wake_cnt;
    bus_lvl = 1'b0; cyc(1);
    for (int i = 0; i < F + 5; i++) begin
      tick_us = 1'b1; cyc(1); tick_us = 1'b0; cyc(1);
    end
    lowpwr = 1'b0; cyc(1); lowpwr = 1'b1; prewake_low = 1'b1; cyc(2);
    prewake_low = 1'b0;
    bus_lvl = 1'b1; cyc(3);
    check("R8 mid-pulse clear gives no request", wake_cnt - base, 0);

    cyc(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule